// File: doc/BRIEF.md
# Transfer Descriptor Error Retirement

This block sits beside the transaction engine of a full-speed/low-speed USB host controller and tracks error outcomes for the transfer descriptor that is currently being executed. When a descriptor is fetched, the engine loads its two-bit error budget and its Active bit into the block. The engine reports each failed transaction with a strobe. The block also watches the raw received bit stream, after NRZI decoding, for bit stuffing violations.

Each error uses up one unit of the budget. While budget remains, the descriptor stays Active and is retried in a later frame. When the budget runs out, the descriptor is retired: Active is cleared and Stalled is set. A USB error request is then held pending until the next end-of-frame strobe. At that strobe it becomes a sticky status bit, which drives the interrupt line. Software clears the status bit with a write-one-to-clear strobe. The engine writes the updated budget, Active and Stalled values back to descriptor memory.

Top module: `td_err_retire`

## Requirements
- R1: After reset, err_cnt, td_active, td_stalled, stuff_err, usb_err_sts and irq are all 0.
- R2: A td_load pulse captures load_cnt and load_active into err_cnt and td_active and clears td_stalled. The new values are visible after that clock edge. td_load takes priority over any error in the same cycle.
- R3: A bit stuffing violation is the seventh consecutive 1 on rx_bit among cycles with rx_valid high. It raises stuff_err for exactly one cycle after the edge that samples that bit. Further 1s in the same run raise no further flags.
- R4: The run of ones restarts on any valid 0 bit and in any cycle with rx_sync high. The bit offered in an rx_sync cycle is discarded. Cycles with rx_valid low neither extend nor break the run.
- R5: Each error event, whether an xact_err pulse or a stuffing violation, lowers a nonzero err_cnt by exactly one while td_active is 1. A transaction error and a stuffing violation in the same cycle count as one error.
- R6: When err_cnt is 0 after a load, errors are unlimited: err_cnt stays 0 and the descriptor is never stalled.
- R7: The error that takes err_cnt from 1 to 0 clears td_active and sets td_stalled on the same edge. An error that leaves err_cnt above 0 keeps td_active at 1.
- R8: Errors while td_active is 0 change nothing.
- R9: A stall is not reported at once. usb_err_sts is set only by the first eof pulse that follows the edge where the stall occurred.
- R10: usb_err_sts stays set until an sts_clr pulse. If an eof delivers a pending stall in the same cycle as an sts_clr, the status is set.
- R11: irq equals usb_err_sts at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| td_load | input | 1 | Load a freshly fetched descriptor |
| load_cnt | input | CNT_W | Error budget field of the fetched descriptor |
| load_active | input | 1 | Active bit of the fetched descriptor |
| xact_err | input | 1 | Failed transaction strobe (timeout, CRC, etc.) |
| rx_valid | input | 1 | rx_bit carries a received bit this cycle |
| rx_bit | input | 1 | Received bit after NRZI decoding |
| rx_sync | input | 1 | Start of packet seen; restarts the run of ones |
| eof | input | 1 | End-of-frame strobe |
| sts_clr | input | 1 | Write-one-to-clear strobe for the error status |
| err_cnt | output | CNT_W | Remaining error budget, for write-back |
| td_active | output | 1 | Active bit, for write-back |
| td_stalled | output | 1 | Stalled bit, for write-back |
| stuff_err | output | 1 | One-cycle bit stuffing violation flag |
| usb_err_sts | output | 1 | Sticky USB error interrupt status |
| irq | output | 1 | Hardware interrupt request |

## Verification
The assertions assume that the strobes are plain per-cycle levels. They also assume that a stall cannot be produced twice without a reload, because an inactive descriptor ignores errors. The stimulus drives every strobe for one cycle at a time. It biases the received bits strongly toward 1 so that runs of seven ones occur often, and it interleaves random loads, including budgets of 0 and 1, with end-of-frame and clear pulses. Directed cases cover a run of exactly six ones, a sync pulse in the middle of a run, a coincident clear and delivery, and a load that collides with an error.

// File: rtl/td_err_retire.sv
module td_err_retire #(
  parameter int CNT_W   = 2,
  parameter int RUN_MAX = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             td_load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             load_active,
  input  logic             xact_err,
  input  logic             rx_valid,
  input  logic             rx_bit,
  input  logic             rx_sync,
  input  logic             eof,
  input  logic             sts_clr,
  output logic [CNT_W-1:0] err_cnt,
  output logic             td_active,
  output logic             td_stalled,
  output logic             stuff_err,
  output logic             usb_err_sts,
  output logic             irq
);
  localparam int RUN_W = $clog2(RUN_MAX + 2);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_MAX);
  localparam logic [RUN_W-1:0] RUN_SAT  = RUN_W'(RUN_MAX + 1);

  logic [RUN_W-1:0] ones;
  logic             pend;
  logic             bit_in, stuff_hit, err_evt, counting, last_one;

  assign bit_in    = rx_valid && !rx_sync;
  assign stuff_hit = bit_in && rx_bit && (ones == RUN_LAST);
  assign err_evt   = xact_err || stuff_hit;
  assign counting  = !td_load && err_evt && td_active && (err_cnt != '0);
  assign last_one  = counting && (err_cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones      <= '0;
      stuff_err <= 1'b0;
    end else begin
      stuff_err <= stuff_hit;
      if (rx_sync)
        ones <= '0;
      else if (rx_valid)
        ones <= !rx_bit ? '0 : (ones == RUN_SAT) ? RUN_SAT : ones + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt    <= '0;
      td_active  <= 1'b0;
      td_stalled <= 1'b0;
    end else if (td_load) begin
      err_cnt    <= load_cnt;
      td_active  <= load_active;
      td_stalled <= 1'b0;
    end else if (counting) begin
      err_cnt <= err_cnt - 1'b1;
      if (last_one) begin
        td_active  <= 1'b0;
        td_stalled <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend        <= 1'b0;
      usb_err_sts <= 1'b0;
    end else begin
      pend <= last_one ? 1'b1 : eof ? 1'b0 : pend;
      if (eof && pend)
        usb_err_sts <= 1'b1;
      else if (sts_clr)
        usb_err_sts <= 1'b0;
    end
  end

  assign irq = usb_err_sts;
endmodule

// File: rtl/td_err_retire_chk.sv
module td_err_retire_chk #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             td_load,
  input logic             xact_err,
  input logic             rx_valid,
  input logic             rx_bit,
  input logic             eof,
  input logic             sts_clr,
  input logic [CNT_W-1:0] err_cnt,
  input logic             td_active,
  input logic             td_stalled,
  input logic             stuff_err,
  input logic             usb_err_sts,
  input logic             irq
);
  assert_stuff_on_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err |-> $past(rx_valid && rx_bit));

  assert_stuff_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err |=> !stuff_err);

  assert_unlimited_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!td_load && err_cnt == '0) |=> (err_cnt == '0));

  assert_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!td_load && xact_err && td_active && err_cnt == CNT_W'(1)) |=> (td_stalled && !td_active));

  assert_inactive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!td_load && !td_active) |=> ($stable(err_cnt) && !td_active && $stable(td_stalled)));

  assert_eof_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(usb_err_sts) |-> $past(eof));

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_err_sts && !sts_clr) |=> usb_err_sts);

  always_comb if (rst_n) assert_irq_R11: assert (irq == usb_err_sts);
endmodule

bind td_err_retire td_err_retire_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .td_load(td_load), .xact_err(xact_err),
  .rx_valid(rx_valid), .rx_bit(rx_bit), .eof(eof), .sts_clr(sts_clr),
  .err_cnt(err_cnt), .td_active(td_active), .td_stalled(td_stalled),
  .stuff_err(stuff_err), .usb_err_sts(usb_err_sts), .irq(irq)
);

// File: tb/test_td_err_retire.sv
module test_td_err_retire;
  logic clk = 0, rst_n = 0;
  logic td_load = 0, load_active = 0, xact_err = 0;
  logic rx_valid = 0, rx_bit = 0, rx_sync = 0, eof = 0, sts_clr = 0;
  logic [1:0] load_cnt = 0;
  logic [1:0] err_cnt;
  logic td_active, td_stalled, stuff_err, usb_err_sts, irq;

  int total = 0, bad = 0;
  int m_ones = 0;
  logic [1:0] m_cnt = 0;
  logic m_act = 0, m_stl = 0, m_pend = 0, m_sts = 0, m_stuff = 0;
  bit done = 0;

  td_err_retire i_td_err_retire (.*);

  always #2 clk = ~clk;

  function automatic bit stuff_hit_f(int ones, logic v, logic b, logic s);
    return v && !s && b && ones == 6;
  endfunction

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_step();
    bit hit, cnt_ok, last;
    hit = stuff_hit_f(m_ones, rx_valid, rx_bit, rx_sync);
    if (rx_sync) m_ones = 0;
    else if (rx_valid) m_ones = rx_bit ? (m_ones < 7 ? m_ones + 1 : 7) : 0;
    m_stuff = hit;
    cnt_ok = !td_load && (xact_err || hit) && m_act && m_cnt != 0;
    last = cnt_ok && m_cnt == 1;
    if (eof && m_pend) m_sts = 1;
    else if (sts_clr) m_sts = 0;
    m_pend = last ? 1 : (eof ? 0 : m_pend);
    if (td_load) begin
      m_cnt = load_cnt; m_act = load_active; m_stl = 0;
    end else if (cnt_ok) begin
      m_cnt = m_cnt - 1;
      if (last) begin m_act = 0; m_stl = 1; end
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R3 stuff_err", stuff_err, m_stuff);
    chk("R5 err_cnt", err_cnt, m_cnt);
    chk("R7 td_active", td_active, m_act);
    chk("R7 td_stalled", td_stalled, m_stl);
    chk("R9 usb_err_sts", usb_err_sts, m_sts);
    chk("R11 irq", irq, usb_err_sts);
    td_load = 0; xact_err = 0; rx_valid = 0; rx_sync = 0; eof = 0; sts_clr = 0;
  endtask

  task automatic load(int c, bit a);
    td_load = 1; load_cnt = 2'(c); load_active = a; step();
  endtask

  task automatic send_bit(bit b);
    rx_valid = 1; rx_bit = b; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 err_cnt", err_cnt, 0);
    chk("R1 td_active", td_active, 0);
    chk("R1 td_stalled", td_stalled, 0);
    chk("R1 stuff_err", stuff_err, 0);
    chk("R1 usb_err_sts", usb_err_sts, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1;
    @(negedge clk);

    load(3, 1);
    chk("R2 load cnt", err_cnt, 3);
    chk("R2 load active", td_active, 1);
    xact_err = 1; step();
    chk("R5 decrement", err_cnt, 2);
    chk("R7 still active", td_active, 1);

    rx_sync = 1; step();
    for (int i = 0; i < 6; i++) send_bit(1);
    chk("R3 six ones no flag", stuff_err, 0);
    send_bit(0);
    for (int i = 0; i < 3; i++) send_bit(1);
    rx_sync = 1; rx_valid = 1; rx_bit = 1; step();
    for (int i = 0; i < 6; i++) send_bit(1);
    chk("R4 sync restarted run", stuff_err, 0);
    step();
    xact_err = 1; rx_valid = 1; rx_bit = 1; step();
    chk("R3 seventh one flags", stuff_err, 1);
    chk("R5 coincident counts once", err_cnt, 1);
    send_bit(1);
    chk("R3 no second flag", stuff_err, 0);
    xact_err = 1; eof = 1; step();
    chk("R7 retired stalled", td_stalled, 1);
    chk("R9 not same-edge", usb_err_sts, 0);
    xact_err = 1; step();
    chk("R8 inactive ignores", err_cnt, 0);
    chk("R8 still stalled", td_stalled, 1);
    eof = 1; sts_clr = 1; step();
    chk("R10 set wins over clear", usb_err_sts, 1);
    step();
    chk("R10 sticky", usb_err_sts, 1);
    sts_clr = 1; step();
    chk("R10 cleared", usb_err_sts, 0);

    load(0, 1);
    for (int i = 0; i < 5; i++) begin xact_err = 1; step(); end
    chk("R6 unlimited cnt", err_cnt, 0);
    chk("R6 unlimited active", td_active, 1);

    load(1, 1);
    td_load = 1; load_cnt = 2; load_active = 1; xact_err = 1; step();
    chk("R2 load priority", err_cnt, 2);
    chk("R2 load priority stall", td_stalled, 0);

    void'($urandom(1234));
    for (int n = 0; n < 6000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      td_load = (r < 3);
      load_cnt = 2'($urandom_range(0, 3));
      load_active = ($urandom_range(0, 9) != 0);
      xact_err = ($urandom_range(0, 19) == 0);
      rx_valid = ($urandom_range(0, 4) != 0);
      rx_bit = ($urandom_range(0, 9) != 0);
      rx_sync = ($urandom_range(0, 29) == 0);
      eof = ($urandom_range(0, 24) == 0);
      sts_clr = ($urandom_range(0, 39) == 0);
      step();
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule